// File: doc/BRIEF.md
# Receive Queue Steering Unit

This block selects a receive queue for each incoming TCP/IPv4 packet. An upstream parser supplies the two IPv4 addresses and the two TCP port numbers of a packet over a valid/ready stream. The block combines them into one 32-bit value with XOR. It reduces that value modulo a small prime to get a table index. It then reads a redirection table at that index to get the queue number. The result leaves on a second valid/ready stream. In the same cycle the result is taken, a one-hot interrupt request pulses on the line that belongs to the chosen queue.

Driver software fills the redirection table through a plain write port (enable, index, queue number). After reset, the table deals indices round-robin across the queues, so traffic is spread before software writes anything.

The datapath has three register stages: captured fields, then folded and reduced index, then table result. All stages advance together. Back-pressure rules: a transfer happens on an edge where valid and ready are both high. The input's ready drops only while a result sits at the output with its ready low, and in that state the whole pipeline holds. The output's valid, once high, stays high with its queue number unchanged until it is taken.

Top module: `rxq_steer`

## Requirements
- R1: A packet is accepted on a rising edge with in_valid and in_ready high; in_ready is low exactly when out_valid is high and out_ready is low.
- R2: The raw hash is in_src_ip XOR in_dst_ip XOR in_src_port XOR in_dst_port, where each 16-bit port is zero-extended to 32 bits.
- R3: The table index is the raw hash modulo PRIME (default 31), so it is always below PRIME.
- R4: out_queue equals the redirection table entry at the index. With no stall, out_valid rises three edges after the packet is accepted.
- R5: After reset, table entry i holds i modulo NUM_Q (default 4 queues, 2-bit queue numbers, 32 entries).
- R6: With cfg_we high, cfg_data is written to entry cfg_addr on the edge. A packet whose table read falls on that same edge gets the old value, and packets read later get the new value.
- R7: out_irq bit q is high only in a cycle where out_valid and out_ready are high and out_queue equals q. All bits are low in every other cycle, so at most one bit is ever high.
- R8: While out_valid is high and out_ready is low, out_valid and out_queue hold their values. Results leave in arrival order, with none dropped and none repeated.
- R9: With out_ready held high, one packet is accepted and one result delivered on every clock.
- R10: During and right after reset, in_ready is high, out_valid is low and out_irq is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Packet fields valid |
| in_ready | output | 1 | Block can take a packet |
| in_src_ip | input | 32 | IPv4 source address |
| in_dst_ip | input | 32 | IPv4 destination address |
| in_src_port | input | 16 | TCP source port |
| in_dst_port | input | 16 | TCP destination port |
| out_valid | output | 1 | Queue result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_queue | output | QW (2) | Chosen receive queue |
| out_irq | output | NUM_Q (4) | One-hot interrupt pulse for the chosen queue |
| cfg_we | input | 1 | Redirection table write enable |
| cfg_addr | input | IW (5) | Table entry to write |
| cfg_data | input | QW (2) | Queue number to store |

## Verification
The hardest case to reach from the ports is a table write that lands on the same edge as the table read of a packet with the same index. The stimulus sends a packet that hashes to a chosen entry. With out_ready held high, it asserts the write to that entry exactly two cycles after acceptance. A second packet that hashes to the same entry through a different raw value (raw plus 31) then shows the new contents. A long run with out_ready following a pseudo-random bit pattern exercises holds of every length at the output.

// File: rtl/rxq_steer_pkg.sv
package rxq_steer_pkg;

  typedef struct packed {
    logic [31:0] src_ip;
    logic [31:0] dst_ip;
    logic [15:0] src_port;
    logic [15:0] dst_port;
  } rxq_flow_t;

  function automatic logic [31:0] rxq_fold(input rxq_flow_t f);
    return f.src_ip ^ f.dst_ip ^ {16'h0000, f.src_port} ^ {16'h0000, f.dst_port};
  endfunction

endpackage

// File: rtl/rxq_flow_reg.sv
module rxq_flow_reg
  import rxq_steer_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      in_valid,
  input  rxq_flow_t in_flow,
  output logic      out_valid,
  output rxq_flow_t out_flow
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_flow  <= '0;
    end else if (en) begin
      out_valid <= in_valid;
      if (in_valid) out_flow <= in_flow;
    end
  end

endmodule

// File: rtl/rxq_hash_mod.sv
module rxq_hash_mod
  import rxq_steer_pkg::*;
#(
  parameter int PRIME = 31,
  parameter int IW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          in_valid,
  input  rxq_flow_t     in_flow,
  output logic          out_valid,
  output logic [IW-1:0] out_idx
);

  logic [31:0] raw;
  logic [31:0] rem;

  always_comb begin
    raw = rxq_fold(in_flow);
    rem = raw % 32'(PRIME);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
    end else if (en) begin
      out_valid <= in_valid;
      if (in_valid) out_idx <= IW'(rem);
    end
  end

  // R3: a reduced index never reaches the modulus
  a_r3_idx_below_prime: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(out_idx) < 32'(PRIME)));

endmodule

// File: rtl/rxq_redir_table.sv
module rxq_redir_table #(
  parameter int NUM_Q = 4,
  parameter int DEPTH = 32,
  parameter int QW    = 2,
  parameter int IW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          rd_valid,
  input  logic [IW-1:0] rd_idx,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_addr,
  input  logic [QW-1:0] wr_data,
  output logic          out_valid,
  output logic [QW-1:0] out_queue
);

  logic [QW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) mem[e] <= QW'(e % NUM_Q);
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // registered read: a same-edge write is not yet visible here
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_queue <= '0;
    end else if (en) begin
      out_valid <= rd_valid;
      if (rd_valid) out_queue <= mem[rd_idx];
    end
  end

  // R6: a write is visible at its entry one edge later
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/rxq_irq_decode.sv
module rxq_irq_decode #(
  parameter int NUM_Q = 4,
  parameter int QW    = 2
) (
  input  logic             fire,
  input  logic [QW-1:0]    queue,
  output logic [NUM_Q-1:0] irq
);

  for (genvar q = 0; q < NUM_Q; q++) begin : g_line
    assign irq[q] = fire && (queue == QW'(q));
  end

endmodule

// File: rtl/rxq_steer.sv
module rxq_steer
  import rxq_steer_pkg::*;
#(
  parameter int NUM_Q = 4,
  parameter int PRIME = 31,
  localparam int QW    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int IW    = (PRIME > 1) ? $clog2(PRIME) : 1,
  localparam int DEPTH = 1 << IW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_src_ip,
  input  logic [31:0]      in_dst_ip,
  input  logic [15:0]      in_src_port,
  input  logic [15:0]      in_dst_port,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [QW-1:0]    out_queue,
  output logic [NUM_Q-1:0] out_irq,
  input  logic             cfg_we,
  input  logic [IW-1:0]    cfg_addr,
  input  logic [QW-1:0]    cfg_data
);

  rxq_flow_t     in_flow;
  rxq_flow_t     s0_flow;
  logic          s0_valid;
  logic          s1_valid;
  logic [IW-1:0] s1_idx;
  logic          advance;

  assign in_flow = '{src_ip: in_src_ip, dst_ip: in_dst_ip,
                     src_port: in_src_port, dst_port: in_dst_port};

  // one enable for all stages: hold everything while the output waits
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  rxq_flow_reg u_capture (
    .clk(clk), .rst_n(rst_n), .en(advance),
    .in_valid(in_valid), .in_flow(in_flow),
    .out_valid(s0_valid), .out_flow(s0_flow)
  );

  rxq_hash_mod #(.PRIME(PRIME), .IW(IW)) u_hash (
    .clk(clk), .rst_n(rst_n), .en(advance),
    .in_valid(s0_valid), .in_flow(s0_flow),
    .out_valid(s1_valid), .out_idx(s1_idx)
  );

  rxq_redir_table #(.NUM_Q(NUM_Q), .DEPTH(DEPTH), .QW(QW), .IW(IW)) u_table (
    .clk(clk), .rst_n(rst_n), .en(advance),
    .rd_valid(s1_valid), .rd_idx(s1_idx),
    .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_data),
    .out_valid(out_valid), .out_queue(out_queue)
  );

  rxq_irq_decode #(.NUM_Q(NUM_Q), .QW(QW)) u_irq (
    .fire(out_valid && out_ready), .queue(out_queue), .irq(out_irq)
  );

  // R8: a waiting result is held unchanged
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_queue)));

  // R7: interrupt lines pulse only on an output transfer, one at a time
  a_r7_irq_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_irq));
  a_r7_irq_on_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_irq) |-> (out_valid && out_ready));

  // R9: an index ready to read reaches the output when not stalled
  a_r9_flow_through: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && advance) |=> out_valid);

endmodule

// File: tb/rxq_steer_tb_top.sv
module rxq_steer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NQ = 4;
  localparam int PR = 31;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [31:0] in_src_ip, in_dst_ip;
  logic [15:0] in_src_port, in_dst_port;
  logic        out_valid, out_ready;
  logic [1:0]  out_queue;
  logic [3:0]  out_irq;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [1:0]  cfg_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxq_steer #(.NUM_Q(NQ), .PRIME(PR)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_src_ip(in_src_ip), .in_dst_ip(in_dst_ip),
    .in_src_port(in_src_port), .in_dst_port(in_dst_port),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_queue(out_queue), .out_irq(out_irq),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [1:0]  model [32];
  logic [1:0]  expq [2048];
  int          head = 0, tail = 0;
  logic [15:0] lf = 16'hACE1;
  bit          rdy_rand = 0;
  bit          prev_stall = 0;
  logic [1:0]  prev_q = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_idx(input logic [31:0] s, input logic [31:0] d,
                                 input logic [15:0] sp, input logic [15:0] dp);
    logic [31:0] h;
    h = s ^ d ^ {16'h0, sp} ^ {16'h0, dp};
    return int'(h % 32'(PR));
  endfunction

  function automatic logic [15:0] lf_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic tick(input bit iv, input logic [31:0] s, input logic [31:0] d,
                      input logic [15:0] sp, input logic [15:0] dp,
                      input bit we, input logic [4:0] wa, input logic [1:0] wd,
                      output bit acc);
    @(negedge clk);
    in_valid = iv; in_src_ip = s; in_dst_ip = d; in_src_port = sp; in_dst_port = dp;
    cfg_we = we; cfg_addr = wa; cfg_data = wd;
    out_ready = rdy_rand ? lf[0] : 1'b1;
    lf = lf_next(lf);
    #1;
    // R1 ready rule
    chk(in_ready == !(out_valid && !out_ready), "R1 in_ready", int'(in_ready),
        int'(!(out_valid && !out_ready)));
    // R8 hold
    if (prev_stall) begin
      chk(out_valid, "R8 valid held", int'(out_valid), 1);
      chk(out_queue == prev_q, "R8 queue held", int'(out_queue), int'(prev_q));
    end
    if (out_valid && out_ready) begin
      chk(head < tail, "R8 no extra result", head, tail);
      if (head < tail) begin
        chk(out_queue == expq[head], "R4 queue value", int'(out_queue), int'(expq[head]));
        chk(out_irq == (4'b0001 << out_queue), "R7 irq line", int'(out_irq),
            int'(4'b0001 << out_queue));
        head++;
      end
    end else begin
      chk(out_irq == 4'b0000, "R7 irq idle", int'(out_irq), 0);
    end
    acc = iv && in_ready;
    if (acc) begin
      expq[tail] = model[exp_idx(s, d, sp, dp)];
      tail++;
    end
    if (we) model[wa] = wd;
    prev_stall = out_valid && !out_ready;
    prev_q = out_queue;
  endtask

  task automatic send(input logic [31:0] s, input logic [31:0] d,
                      input logic [15:0] sp, input logic [15:0] dp, output int tries);
    bit acc;
    tries = 0;
    acc = 0;
    while (!acc) begin
      tick(1'b1, s, d, sp, dp, 1'b0, 5'd0, 2'd0, acc);
      tries++;
    end
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) tick(1'b0, '0, '0, '0, '0, 1'b0, 5'd0, 2'd0, acc);
  endtask

  initial begin
    int tries, total;
    bit acc;
    rst_n = 1'b0; in_valid = 0; in_src_ip = 0; in_dst_ip = 0; in_src_port = 0;
    in_dst_port = 0; out_ready = 1; cfg_we = 0; cfg_addr = 0; cfg_data = 0;
    for (int i = 0; i < 32; i++) model[i] = 2'(i % NQ); // R5 reset contents
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(in_ready == 1'b1, "R10 in_ready reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R10 out_valid reset", int'(out_valid), 0);
    chk(out_irq == 4'b0, "R10 irq reset", int'(out_irq), 0);
    rst_n = 1'b1;
    @(posedge clk);

    // R5, R3, R9: full index sweep twice through the reset table, no stall
    total = 0;
    for (int k = 0; k < 62; k++) begin
      send(32'(k), 32'h0, 16'h0, 16'h0, tries);
      total += tries;
    end
    chk(total == 62, "R9 one accept per clock", total, 62);
    idle(2);
    chk(out_valid == 1'b1, "R4 latency three edges", int'(out_valid), 1);
    idle(4);
    chk(head == 62, "R9 all delivered", head, 62);

    // R2: mixed fields, ports with high bits to test zero extension
    for (int k = 0; k < 40; k++) begin
      send(32'h9E3779B9 * 32'(k + 1), {16'(k * 977), 16'hF0F0 ^ 16'(k)},
           16'hFFFF - 16'(k * 7), 16'(k * 1031), tries);
    end
    idle(6);

    // R6: reprogram table, then sweep again
    for (int i = 0; i < 32; i++)
      tick(1'b0, '0, '0, '0, '0, 1'b1, 5'(i), 2'((i * 3 + 1) % NQ), acc);
    for (int k = 0; k < 62; k++) send(32'(k), 32'h0, 16'h0, 16'h0, tries);
    idle(6);

    // R6: write on the same edge as the read of entry 5
    tick(1'b1, 32'd5, 32'h0, 16'h0, 16'h0, 1'b0, 5'd0, 2'd0, acc);
    tick(1'b0, '0, '0, '0, '0, 1'b0, 5'd0, 2'd0, acc);
    tick(1'b0, '0, '0, '0, '0, 1'b1, 5'd5, model[5] + 2'd2, acc);
    tick(1'b1, 32'd36, 32'h0, 16'h0, 16'h0, 1'b0, 5'd0, 2'd0, acc);
    idle(6);
    chk(head == tail, "R6 results delivered", head, tail);

    // R8, R1: random back-pressure
    rdy_rand = 1;
    for (int k = 0; k < 300; k++) begin
      logic [31:0] a, b;
      a = {lf, lf_next(lf)} ^ 32'(k * 40503);
      b = {lf_next(lf), lf} + 32'(k);
      send(a, b, lf ^ 16'(k), 16'(k * 13), tries);
    end
    rdy_rand = 0;
    idle(8);
    chk(head == tail, "R8 no loss", head, tail);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule